// File: doc/BRIEF.md
# Receive Signal-Loss Alarm Monitor

This block supervises the recovered receive stream of a serial link. Each clock it takes one 4-bit receive word and looks for level changes. A change can sit inside the word or across the seam between two words. Bit 0 is the earliest bit in time and bit 3 is the latest. When too many words in a row carry no change at all, the block raises a loss-of-signal alarm. An optical module's signal-detect line can also raise the alarm. The polarity of that line is set by a select pin.

Once raised, the alarm stays latched. Returning transitions do not release it. Only a strobe from the frame synchroniser, reporting that a framing pattern was found, clears it. While the alarm is high, the block asks the transmitter to send all zeros and asks the clock logic to lock to the local reference. The receive words keep flowing to the parallel output whatever the alarm state.

Top module: `sig_loss_mon`

## Requirements
- R1: While reset is asserted (rstN low), and on the first clock after its release, losFlag, txZeroForce and refLockSel are 0. The quiet-word count is zero and the stored previous last bit is 0.
- R2: A word is quiet when all of the following hold: bit 0 equals the stored last bit (bit 3) of the previous word, and bits 1, 2 and 3 each equal the bit before them. Any word that is not quiet restarts the quiet count from zero. Alternating 4'b0000 and 4'b1111 words are therefore never quiet.
- R3: With QUIET_CYCLES = Q, losFlag rises at the clock edge that captures the (Q+1)th consecutive quiet word. After only Q consecutive quiet words, losFlag is still 0.
- R4: The signal-detect input is active when sigDetIn differs from polSel. With polSel = 0 it is active high; with polSel = 1 it is active low.
- R5: An active signal-detect input sets losFlag at the next clock edge. While it remains active, frameFound cannot clear losFlag.
- R6: Once set, losFlag stays 1 when transitions return, for as long as frameFound is 0.
- R7: frameFound = 1 clears losFlag at the next edge, provided neither set condition (R3 expiry or R5) holds in that cycle. A set condition present together with frameFound leaves losFlag at 1. frameFound while losFlag is 0 has no effect.
- R8: txZeroForce and refLockSel both equal losFlag in every cycle.
- R9: rxDataOut equals rxWord captured at the previous clock edge, whatever the value of losFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxWord | input | 4 | Recovered receive word, bit 0 earliest |
| sigDetIn | input | 1 | External optical signal-detect line |
| polSel | input | 1 | Signal-detect polarity select |
| frameFound | input | 1 | Framing-pattern-found strobe from the frame synchroniser |
| rxDataOut | output | 4 | Receive word, delayed one cycle |
| losFlag | output | 1 | Latched loss-of-signal alarm |
| txZeroForce | output | 1 | Request to force transmit data to zeros |
| refLockSel | output | 1 | Request to lock the recovered clock to the reference |

## Verification
A wrong quiet count or a wrong stored last bit shows up as losFlag rising one or more cycles early or late against a run of quiet words. The run lengths are driven right at Q and Q+1, so such an error is seen within one cycle of the boundary. A broken latch or a wrong set/clear priority shows up at the first cycle after transitions return, after a frameFound pulse, or after signal detect is released. These faults are caught within one cycle, because the reference model is compared against all four outputs on every clock.

// File: rtl/sig_loss_pkg.sv
package sig_loss_pkg;
  // Strobes passed from the datapath to the alarm control each cycle.
  typedef struct packed {
    logic quietExpire; // quiet run has gone past the window in this word
    logic sdActive;    // external detect line is in its active state
  } lossEvt_t;
endpackage

// File: rtl/sig_loss_dp.sv
module sig_loss_dp
  import sig_loss_pkg::*;
#(
  parameter int QUIET_CYCLES = 288,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              sigDetIn,
  input  logic              polSel,
  output logic [WORD_W-1:0] rxDataOut,
  output lossEvt_t          evt
);
  localparam int CNT_W = $clog2(QUIET_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(QUIET_CYCLES);

  logic [WORD_W-1:0] rxHoldQ;
  logic [WORD_W-1:0] edgeVec;
  logic [CNT_W-1:0]  quietCntQ;
  logic              hasEdge;

  // Seam between words: the latest bit of the previous word against bit 0.
  assign edgeVec[0] = rxWord[0] ^ rxHoldQ[WORD_W-1];
  // Changes inside the current word.
  generate
    for (genvar i = 1; i < WORD_W; i++) begin : g_inner
      assign edgeVec[i] = rxWord[i] ^ rxWord[i-1];
    end
  endgenerate
  assign hasEdge = |edgeVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHoldQ   <= '0;
      quietCntQ <= '0;
    end else begin
      rxHoldQ <= rxWord;
      if (hasEdge)
        quietCntQ <= '0;
      else if (quietCntQ != CNT_LIMIT)
        quietCntQ <= quietCntQ + 1'b1;
    end
  end

  assign rxDataOut       = rxHoldQ;
  assign evt.quietExpire = !hasEdge && (quietCntQ == CNT_LIMIT);
  assign evt.sdActive    = sigDetIn ^ polSel;

  // R2: the run counter never goes past its window.
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    quietCntQ <= CNT_LIMIT);
  // R9: the receive word passes through one cycle later.
  a_r9_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> rxDataOut == $past(rxWord));
endmodule

// File: rtl/sig_loss_ctrl.sv
module sig_loss_ctrl
  import sig_loss_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  lossEvt_t evt,
  input  logic     frameFound,
  output logic     losFlag,
  output logic     txZeroForce,
  output logic     refLockSel
);
  logic losQ;
  logic setReq;

  assign setReq = evt.quietExpire | evt.sdActive;

  // Set has priority over the clear from the frame synchroniser.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      losQ <= 1'b0;
    else if (setReq)
      losQ <= 1'b1;
    else if (frameFound)
      losQ <= 1'b0;
  end

  assign losFlag     = losQ;
  assign txZeroForce = losQ;
  assign refLockSel  = losQ;

  // R3: an expired quiet window raises the alarm.
  a_r3_quiet_sets: assert property (@(posedge clk) disable iff (!rstN)
    evt.quietExpire |=> losQ);
  // R5: an active detect line wins over a framing strobe.
  a_r5_detect_blocks_clear: assert property (@(posedge clk) disable iff (!rstN)
    evt.sdActive && frameFound |=> losQ);
  // R6: the alarm holds without a framing strobe.
  a_r6_latched: assert property (@(posedge clk) disable iff (!rstN)
    losQ && !frameFound |=> losQ);
  // R7: a framing strobe with no set condition clears the alarm.
  a_r7_frame_clears: assert property (@(posedge clk) disable iff (!rstN)
    frameFound && !evt.sdActive && !evt.quietExpire |=> !losQ);
endmodule

// File: rtl/sig_loss_mon.sv
module sig_loss_mon
  import sig_loss_pkg::*;
#(
  parameter int QUIET_CYCLES = 288
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] rxWord,
  input  logic       sigDetIn,
  input  logic       polSel,
  input  logic       frameFound,
  output logic [3:0] rxDataOut,
  output logic       losFlag,
  output logic       txZeroForce,
  output logic       refLockSel
);
  lossEvt_t evt;

  sig_loss_dp #(.QUIET_CYCLES(QUIET_CYCLES), .WORD_W(4)) u_dp (
    .clk(clk), .rstN(rstN), .rxWord(rxWord), .sigDetIn(sigDetIn),
    .polSel(polSel), .rxDataOut(rxDataOut), .evt(evt)
  );

  sig_loss_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .frameFound(frameFound),
    .losFlag(losFlag), .txZeroForce(txZeroForce), .refLockSel(refLockSel)
  );

  // R4: a detect line opposite to the polarity select raises the alarm.
  a_r4_polarity: assert property (@(posedge clk) disable iff (!rstN)
    (sigDetIn != polSel) |=> losFlag);
endmodule

// File: tb/sig_loss_mon_tb.sv
module sig_loss_mon_tb;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] rxWord = 4'b0;
  logic sigDetIn = 1'b0, polSel = 1'b0, frameFound = 1'b0;
  logic [3:0] rxDataOut;
  logic losFlag, txZeroForce, refLockSel;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit running = 0;

  // Behavioural reference state.
  int  runM = 0;
  bit  lastBitM = 0;
  bit  losM = 0;
  logic [3:0] dataM = 4'b0;

  sig_loss_mon #(.QUIET_CYCLES(Q)) u_dut (
    .clk(clk), .rstN(rstN), .rxWord(rxWord), .sigDetIn(sigDetIn),
    .polSel(polSel), .frameFound(frameFound), .rxDataOut(rxDataOut),
    .losFlag(losFlag), .txZeroForce(txZeroForce), .refLockSel(refLockSel)
  );

  always #4 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runM = 0; lastBitM = 0; losM = 0; dataM = 4'b0;
    end else begin
      bit quiet;
      quiet = (rxWord == 4'b0000 && !lastBitM) || (rxWord == 4'b1111 && lastBitM);
      runM = quiet ? runM + 1 : 0;
      if (runM > Q || (sigDetIn != polSel)) losM = 1;
      else if (frameFound) losM = 0;
      lastBitM = rxWord[3];
      dataM = rxWord;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    check(losFlag == losM, phase, "losFlag", losFlag, losM);
    check(txZeroForce == losM, "R8", "txZeroForce", txZeroForce, losM);
    check(refLockSel == losM, "R8", "refLockSel", refLockSel, losM);
    check(rxDataOut == dataM, "R9", "rxDataOut", rxDataOut, dataM);
  end

  task automatic step(input logic [3:0] w, input bit sd, input bit pol, input bit ff);
    @(negedge clk);
    rxWord = w; sigDetIn = sd; polSel = pol; frameFound = ff;
  endtask

  task automatic peek;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(losFlag == 0 && txZeroForce == 0 && refLockSel == 0, "R1",
          "outputs in reset", losFlag, 0);
    rstN = 1'b1;
    running = 1;
    peek();
    check(losFlag == 0, "R1", "losFlag after release", losFlag, 0);

    phase = "R2";
    for (int i = 0; i < 40; i++) step((i % 2) ? 4'b1111 : 4'b0000, 0, 0, 0);
    for (int i = 0; i < 30; i++) step(4'b0101, 0, 0, 0);
    peek();
    check(losFlag == 0, "R2", "seam transitions keep alarm low", losFlag, 0);

    phase = "R3";
    step(4'b0101, 0, 0, 0);
    for (int i = 0; i < Q; i++) step(4'b0000, 0, 0, 0);
    peek();
    check(losFlag == 0, "R3", "after Q quiet words", losFlag, 0);
    step(4'b0000, 0, 0, 0);
    peek();
    check(losFlag == 1, "R3", "after Q+1 quiet words", losFlag, 1);

    phase = "R6";
    for (int i = 0; i < 20; i++) step(4'b0110, 0, 0, 0);
    peek();
    check(losFlag == 1, "R6", "latched with transitions back", losFlag, 1);

    phase = "R7";
    step(4'b0110, 0, 0, 1);
    peek();
    check(losFlag == 0, "R7", "cleared by frameFound", losFlag, 0);
    step(4'b1001, 0, 0, 1);
    peek();
    check(losFlag == 0, "R7", "frameFound while clear", losFlag, 0);

    phase = "R4";
    step(4'b0110, 1, 0, 0);
    peek();
    check(losFlag == 1, "R4", "active-high detect", losFlag, 1);
    phase = "R5";
    step(4'b0110, 1, 0, 1);
    peek();
    check(losFlag == 1, "R5", "detect blocks clear", losFlag, 1);
    step(4'b0110, 1, 1, 1);
    peek();
    check(losFlag == 0, "R4", "polSel=1 sd=1 inactive, cleared", losFlag, 0);
    step(4'b0110, 0, 1, 0);
    peek();
    check(losFlag == 1, "R4", "active-low detect", losFlag, 1);
    step(4'b0110, 1, 1, 1);

    phase = "R7";
    step(4'b1010, 0, 0, 0);
    for (int i = 0; i < Q + 4; i++) step(4'b0000, 0, 0, 1);
    peek();
    check(losFlag == 1, "R7", "quiet expiry wins over frameFound", losFlag, 1);
    step(4'b0110, 0, 0, 1);

    phase = "R6";
    begin
      int hold = 0;
      bit pol = 0;
      logic [3:0] w = 4'b0;
      for (int i = 0; i < 4000; i++) begin
        bit sd;
        if (hold == 0 && ($urandom % 40) == 0) hold = 5 + $urandom % 20;
        if (hold > 0) begin
          w = {4{w[3]}};
          hold--;
        end else begin
          w = 4'($urandom);
        end
        if (($urandom % 300) == 0) pol = ~pol;
        sd = (($urandom % 60) == 0) ? ~pol : pol;
        step(w, sd, pol, ($urandom % 20) == 0);
      end
    end
    step(4'b0110, polSel, polSel, 0);
    peek();
    running = 0;
    finish_run();
  end
endmodule